// File: doc/BRIEF.md
# Trap entry and return controller

This block sits beside the execute stage of a small processor and handles two privileged control-flow events. When the core issues a software trap, the block adds a base value to an offset and folds the low bits of the sum into an 8-bit trap number. That number always lies in the upper half of the vector space. The number appears for one cycle with a request pulse so that an interrupt queue outside this block can take it.

When the core issues a return-from-trap, the block checks the supervisor bit, the trap-enable bit and the debug state in a fixed priority order. From that check it picks one of five outcomes: a user-mode return that may halt, an illegal-instruction request, a normal return to the saved PC, a debug return to the debug saved PC, or a plain step to the next instruction. The block holds the three status bits and the debug-state flag itself. The core can load the status bits through a write port, and a debug-entry strobe marks debug state.

All results are registered and are visible in the cycle after the strobe.

Top module: `trap_ctrl`

## Requirements
- R1: One cycle after `trap_i`, `trap_num_o` equals ((`base_i` + `offset_i`) mod 128) + 128, so bit 7 is always 1 and bits 6..0 are the low seven bits of the sum, wrapping at 2^32.
- R2: A return taken while the supervisor bit is 0 gives `npc_o` = PC+4 with no exception request. `halt_o` is 1 exactly when the trap-enable bit is 0. The status bits are unchanged.
- R3: A return taken with supervisor 1 and trap-enable 1 raises `exc_req_o` (illegal instruction) without halt, gives `npc_o` = PC+4 and leaves the status unchanged.
- R4: A return taken with supervisor 1, trap-enable 0, not in debug state and `dbgf_i` = 0 gives `npc_o` = `saved_pc_i`, sets trap-enable to 1 and copies the previous-supervisor bit into supervisor.
- R5: A return taken with supervisor 1, trap-enable 0, in debug state and `dbgf_i` = 1 gives `npc_o` = `dbg_saved_pc_i`. It loads supervisor from `dbg_saved_sup_i` and trap-enable from `dbg_saved_ten_i`, keeps previous-supervisor, and clears debug state.
- R6: Any other return (supervisor 1, trap-enable 0, with the debug state and `dbgf_i` not matching) gives `npc_o` = PC+4, with no exception, no halt and no status change.
- R7: The status is `stat_o` = {supervisor, previous-supervisor, trap-enable} (bit 2, bit 1, bit 0). A return updates it on the clock edge that samples the strobe. `stat_wr_i` loads `stat_wdata_i` in the same layout, but a return taken in the same cycle wins and the write is dropped.
- R8: `trap_req_o` is high for exactly the cycle after each cycle with `trap_i` high. When `trap_i` and `rett_i` are both high, the return is ignored: no `npc_vld_o`, and no status or debug-state change from it.
- R9: Synchronous active-low reset gives supervisor 1, previous-supervisor 0, trap-enable 0, debug state 0, and all request, valid and halt outputs 0.
- R10: `npc_vld_o` is high for exactly the cycle after each return that is taken. `exc_req_o` and `halt_o` are high only in such a cycle, and never both.
- R11: `dbg_enter_i` sets debug state on the next edge. A debug return (R5) in the same cycle wins and leaves debug state clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_i | input | 1 | Software trap strobe |
| rett_i | input | 1 | Return-from-trap strobe |
| dbgf_i | input | 1 | Debug-field qualifier of the return |
| pc_i | input | 32 | PC of the strobed instruction |
| base_i | input | 32 | Trap base value |
| offset_i | input | 32 | Trap offset value |
| saved_pc_i | input | 32 | PC saved at normal trap entry |
| dbg_saved_pc_i | input | 32 | PC saved at debug entry |
| dbg_saved_sup_i | input | 1 | Supervisor bit saved at debug entry |
| dbg_saved_ten_i | input | 1 | Trap-enable bit saved at debug entry |
| stat_wr_i | input | 1 | Status load strobe |
| stat_wdata_i | input | 3 | Status load value {sup, prev_sup, trap_en} |
| dbg_enter_i | input | 1 | Debug-state entry strobe |
| trap_req_o | output | 1 | Trap request pulse |
| trap_num_o | output | 8 | Trap number |
| npc_vld_o | output | 1 | Next-PC valid pulse after a return |
| npc_o | output | 32 | Next PC chosen by the return |
| exc_req_o | output | 1 | Illegal-instruction request |
| halt_o | output | 1 | Halt indication |
| stat_o | output | 3 | Status {sup, prev_sup, trap_en} |
| dbg_state_o | output | 1 | Debug running state |

## Verification
The debug return is the hardest outcome to reach from the ports. It needs three things at once: debug state entered earlier, status loaded to supervisor 1 with trap-enable 0, and a return carrying `dbgf_i` = 1. A single such return also changes the status that the next return depends on. The stimulus therefore biases its random mix toward debug-entry strobes and status loads that clear trap-enable. Directed sequences then set up each of the five return outcomes in turn, along with the same-cycle collisions of trap with return, return with status load, and debug return with debug entry.

// File: rtl/trapctl_pkg.sv
`timescale 1ns/1ps
// Shared types for the trap entry/return controller.
// Assumes a three-bit status word ordered {sup, prev_sup, trap_en}.
package trapctl_pkg;

    typedef struct packed {
        logic sup;
        logic prev_sup;
        logic trap_en;
    } stat_t;

    typedef enum logic [2:0] {
        RK_USER    = 3'd0,
        RK_ILLEGAL = 3'd1,
        RK_NORMAL  = 3'd2,
        RK_DEBUG   = 3'd3,
        RK_STEP    = 3'd4
    } ret_kind_e;

    localparam stat_t STAT_RESET = '{sup: 1'b1, prev_sup: 1'b0, trap_en: 1'b0};

endpackage

// File: rtl/trap_vec_gen.sv
`timescale 1ns/1ps
// Trap number former: adds base and offset, keeps the low VEC_W-1 bits
// and forces the top bit, registering the result with a one-cycle pulse.
// Assumes VEC_W >= 2 and VEC_W - 1 <= XLEN.
module trap_vec_gen #(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [XLEN-1:0]  base_i,
    input  logic [XLEN-1:0]  offset_i,
    output logic             req_o,
    output logic [VEC_W-1:0] num_o
);
    localparam int LOW_W = VEC_W - 1;

    logic [XLEN-1:0] sum;

    // Full-width sum; only its low bits are kept.
    assign sum = base_i + offset_i;

    // Register the request pulse and the vector number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
            num_o <= '0;
        end else begin
            req_o <= fire_i;
            if (fire_i) begin
                num_o <= {1'b1, sum[LOW_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/trap_rett_decide.sv
`timescale 1ns/1ps
// Return-from-trap decision network (purely combinational).
// Classifies the return by supervisor, trap-enable, debug state and the
// debug-field qualifier, in that priority, then forms next PC, new status
// and the request flags. Assumes the caller gates the result with the strobe.
module trap_rett_decide import trapctl_pkg::*; #(
    parameter int XLEN  = 32,
    parameter int ISTEP = 4
) (
    input  stat_t           stat_i,
    input  logic            dbg_i,
    input  logic            dbgf_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] saved_pc_i,
    input  logic [XLEN-1:0] dbg_saved_pc_i,
    input  logic            dbg_saved_sup_i,
    input  logic            dbg_saved_ten_i,
    output logic [XLEN-1:0] npc_o,
    output stat_t           stat_o,
    output logic            exc_o,
    output logic            halt_o,
    output logic            dbg_clr_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ISTEP);

    ret_kind_e       kind;
    logic [XLEN-1:0] pc_next_seq;

    // Sequential successor used by every non-returning outcome.
    assign pc_next_seq = pc_i + STEP;

    // Priority classification of the return.
    always_comb begin
        if (!stat_i.sup) begin
            kind = RK_USER;
        end else if (stat_i.trap_en) begin
            kind = RK_ILLEGAL;
        end else if (!dbg_i && !dbgf_i) begin
            kind = RK_NORMAL;
        end else if (dbg_i && dbgf_i) begin
            kind = RK_DEBUG;
        end else begin
            kind = RK_STEP;
        end
    end

    // Outcome per class: next PC, status update and flags.
    always_comb begin
        npc_o     = pc_next_seq;
        stat_o    = stat_i;
        exc_o     = 1'b0;
        halt_o    = 1'b0;
        dbg_clr_o = 1'b0;
        unique case (kind)
            RK_USER: begin
                halt_o = !stat_i.trap_en;
            end
            RK_ILLEGAL: begin
                exc_o = 1'b1;
            end
            RK_NORMAL: begin
                npc_o          = saved_pc_i;
                stat_o.trap_en = 1'b1;
                stat_o.sup     = stat_i.prev_sup;
            end
            RK_DEBUG: begin
                npc_o          = dbg_saved_pc_i;
                stat_o.trap_en = dbg_saved_ten_i;
                stat_o.sup     = dbg_saved_sup_i;
                dbg_clr_o      = 1'b1;
            end
            default: begin
                npc_o = pc_next_seq;
            end
        endcase
    end

endmodule

// File: rtl/trap_ctrl_state.sv
`timescale 1ns/1ps
// Holds the status word, the debug-state flag and the registered return
// outputs. A taken return has priority over a status load; a debug return
// has priority over debug entry. Assumes take_i is already qualified.
module trap_ctrl_state import trapctl_pkg::*; #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [XLEN-1:0] npc_i,
    input  stat_t           new_stat_i,
    input  logic            exc_i,
    input  logic            halt_i,
    input  logic            dbg_clr_i,
    input  logic            wr_i,
    input  stat_t           wdata_i,
    input  logic            dbg_enter_i,
    output stat_t           stat_o,
    output logic            dbg_o,
    output logic [XLEN-1:0] npc_o,
    output logic            vld_o,
    output logic            exc_o,
    output logic            halt_o
);
    // Status register: return write-back first, then software load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= STAT_RESET;
        end else if (take_i) begin
            stat_o <= new_stat_i;
        end else if (wr_i) begin
            stat_o <= wdata_i;
        end
    end

    // Debug-state flag: cleared by a debug return, else set by entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_o <= 1'b0;
        end else if (take_i && dbg_clr_i) begin
            dbg_o <= 1'b0;
        end else if (dbg_enter_i) begin
            dbg_o <= 1'b1;
        end
    end

    // Registered return results, flags pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npc_o  <= '0;
            vld_o  <= 1'b0;
            exc_o  <= 1'b0;
            halt_o <= 1'b0;
        end else begin
            vld_o  <= take_i;
            exc_o  <= take_i && exc_i;
            halt_o <= take_i && halt_i;
            if (take_i) begin
                npc_o <= npc_i;
            end
        end
    end

endmodule

// File: rtl/trap_ctrl.sv
`timescale 1ns/1ps
// Trap entry and return controller top. A trap strobe yields a registered
// trap number; a return strobe (ignored when a trap arrives in the same
// cycle) yields next PC, status write-back and request flags one cycle later.
// Assumes the strobes are single-cycle and come from the decode stage.
module trap_ctrl import trapctl_pkg::*; #(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8,
    parameter int ISTEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_i,
    input  logic             rett_i,
    input  logic             dbgf_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  base_i,
    input  logic [XLEN-1:0]  offset_i,
    input  logic [XLEN-1:0]  saved_pc_i,
    input  logic [XLEN-1:0]  dbg_saved_pc_i,
    input  logic             dbg_saved_sup_i,
    input  logic             dbg_saved_ten_i,
    input  logic             stat_wr_i,
    input  logic [2:0]       stat_wdata_i,
    input  logic             dbg_enter_i,
    output logic             trap_req_o,
    output logic [VEC_W-1:0] trap_num_o,
    output logic             npc_vld_o,
    output logic [XLEN-1:0]  npc_o,
    output logic             exc_req_o,
    output logic             halt_o,
    output logic [2:0]       stat_o,
    output logic             dbg_state_o
);
    logic            take;
    stat_t           cur_stat;
    stat_t           nxt_stat;
    logic [XLEN-1:0] dec_npc;
    logic            dec_exc;
    logic            dec_halt;
    logic            dec_dbg_clr;

    // A trap in the same cycle suppresses the return.
    assign take   = rett_i && !trap_i;
    assign stat_o = cur_stat;

    trap_vec_gen #(
        .XLEN (XLEN),
        .VEC_W(VEC_W)
    ) vec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (trap_i),
        .base_i  (base_i),
        .offset_i(offset_i),
        .req_o   (trap_req_o),
        .num_o   (trap_num_o)
    );

    trap_rett_decide #(
        .XLEN (XLEN),
        .ISTEP(ISTEP)
    ) dec_i (
        .stat_i         (cur_stat),
        .dbg_i          (dbg_state_o),
        .dbgf_i         (dbgf_i),
        .pc_i           (pc_i),
        .saved_pc_i     (saved_pc_i),
        .dbg_saved_pc_i (dbg_saved_pc_i),
        .dbg_saved_sup_i(dbg_saved_sup_i),
        .dbg_saved_ten_i(dbg_saved_ten_i),
        .npc_o          (dec_npc),
        .stat_o         (nxt_stat),
        .exc_o          (dec_exc),
        .halt_o         (dec_halt),
        .dbg_clr_o      (dec_dbg_clr)
    );

    trap_ctrl_state #(
        .XLEN(XLEN)
    ) st_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .npc_i      (dec_npc),
        .new_stat_i (nxt_stat),
        .exc_i      (dec_exc),
        .halt_i     (dec_halt),
        .dbg_clr_i  (dec_dbg_clr),
        .wr_i       (stat_wr_i),
        .wdata_i    (stat_t'(stat_wdata_i)),
        .dbg_enter_i(dbg_enter_i),
        .stat_o     (cur_stat),
        .dbg_o      (dbg_state_o),
        .npc_o      (npc_o),
        .vld_o      (npc_vld_o),
        .exc_o      (exc_req_o),
        .halt_o     (halt_o)
    );

endmodule

// File: rtl/trap_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for trap_ctrl, attached by bind. Observes ports only.
module trap_ctrl_chk #(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8,
    parameter int ISTEP = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trap_i,
    input logic             rett_i,
    input logic             dbgf_i,
    input logic [XLEN-1:0]  pc_i,
    input logic [XLEN-1:0]  base_i,
    input logic [XLEN-1:0]  offset_i,
    input logic [XLEN-1:0]  saved_pc_i,
    input logic [XLEN-1:0]  dbg_saved_pc_i,
    input logic             dbg_saved_sup_i,
    input logic             dbg_saved_ten_i,
    input logic             stat_wr_i,
    input logic [2:0]       stat_wdata_i,
    input logic             dbg_enter_i,
    input logic             trap_req_o,
    input logic [VEC_W-1:0] trap_num_o,
    input logic             npc_vld_o,
    input logic [XLEN-1:0]  npc_o,
    input logic             exc_req_o,
    input logic             halt_o,
    input logic [2:0]       stat_o,
    input logic             dbg_state_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ISTEP);

    logic [XLEN-1:0] tsum;
    logic            taken;
    assign tsum  = base_i + offset_i;
    assign taken = rett_i && !trap_i;

    p_num_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |=> trap_req_o && trap_num_o[VEC_W-1]
                   && trap_num_o[VEC_W-2:0] == $past(tsum[VEC_W-2:0]));

    p_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !stat_o[2] |=> npc_o == $past(pc_i) + STEP
            && halt_o == !$past(stat_o[0]) && !exc_req_o && stat_o == $past(stat_o));

    p_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        taken && stat_o[2] && stat_o[0] |=> exc_req_o && !halt_o
            && npc_o == $past(pc_i) + STEP && stat_o == $past(stat_o));

    p_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken && stat_o[2] && !stat_o[0] && !dbg_state_o && !dbgf_i
        |=> npc_o == $past(saved_pc_i) && stat_o[0] && stat_o[2] == $past(stat_o[1]));

    p_debug_r5: assert property (@(posedge clk) disable iff (!rst_n)
        taken && stat_o[2] && !stat_o[0] && dbg_state_o && dbgf_i
        |=> npc_o == $past(dbg_saved_pc_i) && !dbg_state_o
            && stat_o[2] == $past(dbg_saved_sup_i) && stat_o[0] == $past(dbg_saved_ten_i)
            && stat_o[1] == $past(stat_o[1]));

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        taken && stat_o[2] && !stat_o[0] && (dbg_state_o != dbgf_i)
        |=> npc_o == $past(pc_i) + STEP && !exc_req_o && !halt_o && stat_o == $past(stat_o));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_i && !taken |=> stat_o == $past(stat_wdata_i));

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_i |=> !trap_req_o);

    p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> stat_o == 3'b100 && !dbg_state_o && !trap_req_o
            && !npc_vld_o && !exc_req_o && !halt_o);

    p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> !npc_vld_o && !exc_req_o && !halt_o);

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_req_o, halt_o}));

    p_enter_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_enter_i && !taken |=> dbg_state_o);

endmodule

bind trap_ctrl trap_ctrl_chk #(
    .XLEN (XLEN),
    .VEC_W(VEC_W),
    .ISTEP(ISTEP)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_i         (trap_i),
    .rett_i         (rett_i),
    .dbgf_i         (dbgf_i),
    .pc_i           (pc_i),
    .base_i         (base_i),
    .offset_i       (offset_i),
    .saved_pc_i     (saved_pc_i),
    .dbg_saved_pc_i (dbg_saved_pc_i),
    .dbg_saved_sup_i(dbg_saved_sup_i),
    .dbg_saved_ten_i(dbg_saved_ten_i),
    .stat_wr_i      (stat_wr_i),
    .stat_wdata_i   (stat_wdata_i),
    .dbg_enter_i    (dbg_enter_i),
    .trap_req_o     (trap_req_o),
    .trap_num_o     (trap_num_o),
    .npc_vld_o      (npc_vld_o),
    .npc_o          (npc_o),
    .exc_req_o      (exc_req_o),
    .halt_o         (halt_o),
    .stat_o         (stat_o),
    .dbg_state_o    (dbg_state_o)
);

// File: tb/trap_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for trap_ctrl: directed corners plus seeded random stimulus,
// compared against a behavioural model kept in the bench.
module trap_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_i = 1'b0, rett_i = 1'b0, dbgf_i = 1'b0;
    logic [31:0] pc_i = '0, base_i = '0, offset_i = '0;
    logic [31:0] saved_pc_i = '0, dbg_saved_pc_i = '0;
    logic        dbg_saved_sup_i = 1'b0, dbg_saved_ten_i = 1'b0;
    logic        stat_wr_i = 1'b0;
    logic [2:0]  stat_wdata_i = '0;
    logic        dbg_enter_i = 1'b0;
    logic        trap_req_o;
    logic [7:0]  trap_num_o;
    logic        npc_vld_o;
    logic [31:0] npc_o;
    logic        exc_req_o, halt_o;
    logic [2:0]  stat_o;
    logic        dbg_state_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [2:0] m_stat;
    logic       m_dbg;

    always #2.5 clk = ~clk;

    trap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rett_i(rett_i), .dbgf_i(dbgf_i),
        .pc_i(pc_i), .base_i(base_i), .offset_i(offset_i), .saved_pc_i(saved_pc_i),
        .dbg_saved_pc_i(dbg_saved_pc_i), .dbg_saved_sup_i(dbg_saved_sup_i),
        .dbg_saved_ten_i(dbg_saved_ten_i), .stat_wr_i(stat_wr_i),
        .stat_wdata_i(stat_wdata_i), .dbg_enter_i(dbg_enter_i),
        .trap_req_o(trap_req_o), .trap_num_o(trap_num_o), .npc_vld_o(npc_vld_o),
        .npc_o(npc_o), .exc_req_o(exc_req_o), .halt_o(halt_o), .stat_o(stat_o),
        .dbg_state_o(dbg_state_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=0x%08h exp=0x%08h", req, what, act, exp);
        end
    endtask

    // Expected trap number: sum modulo 128, lifted into the upper half.
    function automatic logic [7:0] exp_num(input logic [31:0] b, input logic [31:0] o);
        logic [31:0] s;
        s = b + o;
        return 8'((s % 32'd128) + 32'd128);
    endfunction

    // One cycle: drive at negedge, check just after the next posedge.
    task automatic step(input logic t, input logic r, input logic w, input logic [2:0] wd,
                        input logic de, input logic df, input logic [31:0] pc,
                        input logic [31:0] b, input logic [31:0] o, input logic [31:0] spc,
                        input logic [31:0] dpc, input logic dss, input logic dse);
        logic        re;
        logic [31:0] e_npc;
        logic        e_exc, e_halt, dbg_ret;
        logic [2:0]  n_stat;
        logic        n_dbg;
        string       tag;
        @(negedge clk);
        trap_i = t; rett_i = r; stat_wr_i = w; stat_wdata_i = wd; dbg_enter_i = de;
        dbgf_i = df; pc_i = pc; base_i = b; offset_i = o; saved_pc_i = spc;
        dbg_saved_pc_i = dpc; dbg_saved_sup_i = dss; dbg_saved_ten_i = dse;
        re = r && !t;
        e_npc = pc + 32'd4; e_exc = 1'b0; e_halt = 1'b0; dbg_ret = 1'b0;
        n_stat = m_stat; n_dbg = m_dbg; tag = "R6";
        if (re) begin
            casez ({m_stat[2], m_stat[0], m_dbg, df})
                4'b0???: begin tag = "R2"; e_halt = !m_stat[0]; end
                4'b11??: begin tag = "R3"; e_exc = 1'b1; end
                4'b1000: begin tag = "R4"; e_npc = spc; n_stat = {m_stat[1], m_stat[1], 1'b1}; end
                4'b1011: begin tag = "R5"; e_npc = dpc; n_stat = {dss, m_stat[1], dse};
                               n_dbg = 1'b0; dbg_ret = 1'b1; end
                default: tag = "R6";
            endcase
        end else if (w) begin
            n_stat = wd;
        end
        if (de && !dbg_ret) n_dbg = 1'b1;
        @(posedge clk);
        #1;
        check("R8", "trap_req", 32'(trap_req_o), 32'(t));
        if (t) check("R1", "trap_num", 32'(trap_num_o), 32'(exp_num(b, o)));
        check("R10", "npc_vld", 32'(npc_vld_o), 32'(re));
        if (re) check(tag, "npc", npc_o, e_npc);
        check(re ? tag : "R10", "exc_req", 32'(exc_req_o), 32'(e_exc));
        check(re ? tag : "R10", "halt", 32'(halt_o), 32'(e_halt));
        check(re ? tag : "R7", "stat", 32'(stat_o), 32'(n_stat));
        check("R11", "dbg_state", 32'(dbg_state_o), 32'(n_dbg));
        m_stat = n_stat; m_dbg = n_dbg;
    endtask

    task automatic idle();
        step(0, 0, 0, 3'b0, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0);
    endtask

    task automatic setstat(input logic [2:0] v);
        step(0, 0, 1, v, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0);
    endtask

    // Return helper: the saved PCs are distinct so the path is visible.
    task automatic ret(input logic df, input logic [31:0] pc);
        step(0, 1, 0, 3'b0, 0, df, pc, 32'h0, 32'h0, 32'h0000_4000, 32'h0000_8000, 1, 0);
    endtask

    initial begin
        m_stat = 3'b100; m_dbg = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R9: reset values
        check("R9", "stat", 32'(stat_o), 32'h4);
        check("R9", "dbg_state", 32'(dbg_state_o), 32'h0);
        check("R9", "trap_req", 32'(trap_req_o), 32'h0);
        check("R9", "npc_vld", 32'(npc_vld_o), 32'h0);
        check("R9", "exc_halt", 32'({exc_req_o, halt_o}), 32'h0);

        // R1: number formation corners
        step(1, 0, 0, 3'b0, 0, 0, 32'h100, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0);
        step(1, 0, 0, 3'b0, 0, 0, 32'h100, 32'h7F, 32'h0, 0, 0, 0, 0);
        step(1, 0, 0, 3'b0, 0, 0, 32'h100, 32'h10, 32'hFFFF_FFF0, 0, 0, 0, 0);
        step(1, 0, 0, 3'b0, 0, 0, 32'h100, 32'h1234_5680, 32'h7E, 0, 0, 0, 0);
        idle();

        // R4: normal return from reset status (sup=1, ten=0)
        setstat(3'b010);
        setstat(3'b110);
        ret(0, 32'h0000_0200);
        // R3: supervisor with trap-enable set
        ret(0, 32'h0000_0300);
        // R2: user mode, ten=1 then ten=0 (halt)
        setstat(3'b001);
        ret(0, 32'h0000_0400);
        setstat(3'b000);
        ret(1, 32'h0000_0500);
        // R6: sup=1, ten=0, dbg=0, df=1
        setstat(3'b100);
        ret(1, 32'h0000_0600);
        // R11 and R5: enter debug, then mismatched, then debug return
        step(0, 0, 0, 3'b0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        ret(0, 32'h0000_0700);
        setstat(3'b110);
        ret(1, 32'h0000_0800);
        // R11: debug return together with debug entry
        step(0, 0, 1, 3'b100, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 0, 3'b0, 1, 1, 32'h900, 0, 0, 32'h4000, 32'h8000, 0, 1);
        // R8: trap and return together, return ignored
        setstat(3'b100);
        step(1, 1, 0, 3'b0, 0, 0, 32'hA00, 32'h5, 32'h6, 32'h4000, 0, 0, 0);
        // R7: return wins over status load in the same cycle
        step(0, 1, 1, 3'b011, 0, 0, 32'hB00, 0, 0, 32'h4000, 0, 0, 0);
        idle();

        // Random mix biased toward the debug-return setup
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            logic t, r, w, de, df;
            logic [2:0] wd;
            op = $urandom % 16;
            t  = (op < 3) || (op == 15);
            r  = (op >= 3 && op < 9) || (op == 15) || (op == 14);
            w  = (op >= 9 && op < 12) || (op == 14);
            de = (op == 12) || ((op == 13) && ($urandom % 2 == 1));
            df = ($urandom % 3) != 0;
            wd = ($urandom % 2 == 1) ? 3'(($urandom % 4) << 1) : 3'($urandom % 8);
            step(t, r, w, wd, de, df, {$urandom, 2'b00} & 32'hFFFF_FFFC, $urandom, $urandom,
                 $urandom, $urandom, 1'($urandom % 2), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule